// File: doc/BRIEF.md
# Temperature-Aware Refresh Scheduler

This block tells a DRAM controller's command arbiter when an auto-refresh is owed. A down-counter runs on the controller clock and expires once per average refresh interval. Each expiry adds one refresh to a small backlog, and each grant from the arbiter removes one. While the backlog holds anything, the block raises a request. A busy arbiter can therefore postpone refreshes without losing them, up to a bounded depth.

Two interval lengths are derived at elaboration from the clock period parameter: a cool interval of 7.8 µs and a hot interval of 3.9 µs. Each is rounded down to whole clock cycles, so the real cadence is never slower than required. A temperature input selects the hot interval. It is synchronised first and sampled only when the counter reloads, so every interval that has started runs its full length. A sticky flag records any expiry that arrives while the backlog is already full, which means a refresh has been lost.

Top module: `refresh_sched`

## Requirements
- R1: With `high_temp` low, successive expiries are exactly floor(NORMAL_INTERVAL_PS / CLK_PERIOD_PS) cycles apart.
- R2: With `high_temp` high, successive expiries are exactly floor(HOT_INTERVAL_PS / CLK_PERIOD_PS) cycles apart.
- R3: Reset clears `pending_count`, `refresh_req` and `backlog_overflow`. The first interval after reset has the hot length, whatever `high_temp` is.
- R4: A change of the synchronised temperature takes effect only at the next counter reload. The interval already running finishes at the length it was loaded with.
- R5: An expiry raises `pending_count` by one on the next edge, and an `refresh_ack` lowers it by one. If both happen in the same cycle, the count does not change.
- R6: `refresh_ack` while `pending_count` is zero is ignored: the count stays zero and `refresh_req` stays low.
- R7: `pending_count` never exceeds BACKLOG_MAX. An expiry at BACKLOG_MAX without an ack leaves it at BACKLOG_MAX.
- R8: `backlog_overflow` is set on the edge after an expiry that finds the count at BACKLOG_MAX with no ack. Once set, it stays high until reset.
- R9: `refresh_req` is high exactly when `pending_count` is nonzero.
- R10: `high_temp` passes through SYNC_STAGES flip-flops before the reload logic sees it (none when SYNC_STAGES is 0). A change made one cycle before an expiry is not seen at that reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| high_temp | input | 1 | Asynchronous request for the hot (faster) refresh rate |
| refresh_ack | input | 1 | Arbiter has issued one refresh this cycle |
| refresh_req | output | 1 | At least one refresh is owed |
| pending_count | output | $clog2(BACKLOG_MAX+1) | Number of owed refreshes |
| backlog_overflow | output | 1 | Sticky: an expiry was lost at a full backlog |

## Verification
The bound checker checks the backlog arithmetic on every cycle: increment on expiry, decrement on ack, no change when both coincide, the upper bound, the link between the request and the count, and both the cause and the stickiness of the overflow flag. Only the bench scenarios can show the interval lengths, because those are counts across many cycles. The same applies to reload-time sampling of the temperature, the synchroniser's delay near a reload, and the hot first interval after reset. The bench measures these by timing successive count increments at the ports.

// File: rtl/refresh_sched_pkg.sv
package refresh_sched_pkg;

   // Whole clock cycles that fit in an interval; rounding down keeps refresh early.
   function automatic int interval_cycles(input int interval_ps, input int clk_ps);
      return interval_ps / clk_ps;
   endfunction

   function automatic int bits_for(input int max_value);
      return (max_value < 2) ? 1 : $clog2(max_value + 1);
   endfunction

endpackage

// File: rtl/rfs_temp_sync.sv
module rfs_temp_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign dout = din;
      end else begin : g_chain
         logic [STAGES-1:0] stage_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               stage_q <= '0;
            end else begin
               for (int i = STAGES - 1; i > 0; i--) begin
                  stage_q[i] <= stage_q[i-1];
               end
               stage_q[0] <= din;
            end
         end
         assign dout = stage_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/rfs_interval_timer.sv
module rfs_interval_timer #(
   parameter int NORM_CYCLES = 3120,
   parameter int HOT_CYCLES  = 1560,
   parameter int CNT_W       = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hot_sel,
   output logic expire
);

   logic [CNT_W-1:0] remain_q;
   logic [CNT_W-1:0] reload_val;

   assign reload_val = hot_sel ? CNT_W'(HOT_CYCLES - 1) : CNT_W'(NORM_CYCLES - 1);
   assign expire     = (remain_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         remain_q <= CNT_W'(HOT_CYCLES - 1);
      end else if (expire) begin
         remain_q <= reload_val;
      end else begin
         remain_q <= remain_q - 1'b1;
      end
   end

endmodule

// File: rtl/rfs_backlog.sv
module rfs_backlog #(
   parameter int MAX_OWED = 8,
   parameter int CNT_W    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             add_one,
   input  logic             take_one,
   output logic [CNT_W-1:0] owed,
   output logic             lost
);

   logic full;
   logic take_ok;

   assign full    = (owed == CNT_W'(MAX_OWED));
   assign take_ok = take_one && (owed != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         owed <= '0;
         lost <= 1'b0;
      end else begin
         unique case ({add_one, take_ok})
            2'b10: begin
               if (full) lost <= 1'b1;
               else      owed <= owed + 1'b1;
            end
            2'b01:   owed <= owed - 1'b1;
            default: owed <= owed;
         endcase
      end
   end

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
   import refresh_sched_pkg::*;
#(
   parameter int CLK_PERIOD_PS      = 2500,
   parameter int NORMAL_INTERVAL_PS = 7_800_000,
   parameter int HOT_INTERVAL_PS    = 3_900_000,
   parameter int BACKLOG_MAX        = 8,
   parameter int SYNC_STAGES        = 2
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               high_temp,
   input  logic                               refresh_ack,
   output logic                               refresh_req,
   output logic [$clog2(BACKLOG_MAX+1)-1:0]   pending_count,
   output logic                               backlog_overflow
);

   localparam int NORM_CYCLES = interval_cycles(NORMAL_INTERVAL_PS, CLK_PERIOD_PS);
   localparam int HOT_CYCLES  = interval_cycles(HOT_INTERVAL_PS, CLK_PERIOD_PS);
   localparam int TIMER_W     = bits_for(NORM_CYCLES);
   localparam int PEND_W      = $clog2(BACKLOG_MAX + 1);

   initial begin
      assert (CLK_PERIOD_PS > 0) else $fatal(1, "clock period must be positive");
      assert (HOT_CYCLES >= 2) else $fatal(1, "hot interval shorter than two cycles");
      assert (NORM_CYCLES >= HOT_CYCLES) else $fatal(1, "hot interval longer than normal");
      assert (BACKLOG_MAX >= 1) else $fatal(1, "backlog depth must be at least one");
      assert (SYNC_STAGES >= 0) else $fatal(1, "negative synchroniser depth");
   end

   logic hot_synced;
   logic interval_expire;

   rfs_temp_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (high_temp),
      .dout  (hot_synced)
   );

   rfs_interval_timer #(
      .NORM_CYCLES (NORM_CYCLES),
      .HOT_CYCLES  (HOT_CYCLES),
      .CNT_W       (TIMER_W)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .hot_sel (hot_synced),
      .expire  (interval_expire)
   );

   rfs_backlog #(
      .MAX_OWED (BACKLOG_MAX),
      .CNT_W    (PEND_W)
   ) u_backlog (
      .clk      (clk),
      .rst_n    (rst_n),
      .add_one  (interval_expire),
      .take_one (refresh_ack),
      .owed     (pending_count),
      .lost     (backlog_overflow)
   );

   assign refresh_req = (pending_count != '0);

endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
   parameter int BACKLOG_MAX = 8,
   parameter int PEND_W      = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic              refresh_ack,
   input logic              refresh_req,
   input logic [PEND_W-1:0] pending_count,
   input logic              backlog_overflow
);

   localparam logic [PEND_W-1:0] FULL = PEND_W'(BACKLOG_MAX);

   // R5
   inc_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !refresh_ack && pending_count < FULL) |=> pending_count == $past(pending_count) + 1'b1);

   // R5
   dec_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && refresh_ack && pending_count != '0) |=> pending_count == $past(pending_count) - 1'b1);

   // R5
   both_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && refresh_ack && pending_count != '0) |=> $stable(pending_count));

   // R7
   bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pending_count <= FULL);

   // R9
   req_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> refresh_req);

   // R6
   idle_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && pending_count == '0) |=> (!refresh_req && pending_count == '0));

   // R8
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      backlog_overflow |=> backlog_overflow);

   // R8
   ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !refresh_ack && pending_count == FULL) |=> backlog_overflow);

   // R8
   ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!backlog_overflow && !(tick && !refresh_ack && pending_count == FULL)) |=> !backlog_overflow);

endmodule

bind refresh_sched refresh_sched_chk #(
   .BACKLOG_MAX (BACKLOG_MAX),
   .PEND_W      ($clog2(BACKLOG_MAX + 1))
) u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .tick             (interval_expire),
   .refresh_ack      (refresh_ack),
   .refresh_req      (refresh_req),
   .pending_count    (pending_count),
   .backlog_overflow (backlog_overflow)
);

// File: tb/tb_refresh_sched.sv
module tb_refresh_sched;

   localparam int CLK_PERIOD = 10;
   localparam int CLK_PS     = 1000;
   localparam int NORM_PS    = 20000;
   localparam int HOT_PS     = 10500;
   localparam int NORM_I     = NORM_PS / CLK_PS;   // 20
   localparam int HOT_I      = HOT_PS / CLK_PS;    // 10 (rounded down)
   localparam int MAXB       = 8;
   localparam int PW         = $clog2(MAXB + 1);

   // {high_temp, interval still running, interval after the reload}
   localparam int NVEC = 5;
   localparam int VEC [NVEC][3] = '{
      '{1, NORM_I, HOT_I},
      '{1, HOT_I,  HOT_I},
      '{0, HOT_I,  NORM_I},
      '{0, NORM_I, NORM_I},
      '{1, NORM_I, HOT_I}
   };

   logic          clk = 1'b0;
   logic          rst_n;
   logic          high_temp;
   logic          refresh_ack;
   logic          refresh_req;
   logic [PW-1:0] pending_count;
   logic          backlog_overflow;

   int checks = 0;
   int errors = 0;
   int cyc    = 0;
   int inc_time = 0;
   logic [PW-1:0] prev_pend = '0;
   event inc_ev;
   bit   finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   refresh_sched #(
      .CLK_PERIOD_PS      (CLK_PS),
      .NORMAL_INTERVAL_PS (NORM_PS),
      .HOT_INTERVAL_PS    (HOT_PS),
      .BACKLOG_MAX        (MAXB),
      .SYNC_STAGES        (2)
   ) dut (
      .clk              (clk),
      .rst_n            (rst_n),
      .high_temp        (high_temp),
      .refresh_ack      (refresh_ack),
      .refresh_req      (refresh_req),
      .pending_count    (pending_count),
      .backlog_overflow (backlog_overflow)
   );

   // Timestamps every one-step rise of the backlog, in falling edges.
   always @(negedge clk) begin
      cyc = cyc + 1;
      if (rst_n === 1'b1 && pending_count == prev_pend + 1'b1) begin
         inc_time = cyc;
         -> inc_ev;
      end
      prev_pend = pending_count;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_inc(output int t);
      @(inc_ev);
      t = inc_time;
   endtask

   task automatic ack_pulse();
      refresh_ack = 1'b1;
      @(negedge clk);
      refresh_ack = 1'b0;
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual %0d expected %0d", 0, 1);
         finish_run();
      end
   end

   initial begin
      int start, t_prev, t_a, t_b, t_x;
      rst_n = 1'b0;
      high_temp = 1'b0;
      refresh_ack = 1'b0;
      repeat (3) @(negedge clk);
      // R3 reset state
      check(pending_count == 0, "R3", int'(pending_count), 0);
      check(refresh_req == 0 && backlog_overflow == 0, "R3", int'({refresh_req, backlog_overflow}), 0);
      #1 rst_n = 1'b1;
      start = cyc;

      // R3 first interval is hot even though high_temp is low
      wait_inc(t_prev);
      check(t_prev - start == HOT_I, "R3", t_prev - start, HOT_I);
      // R9 request follows a nonzero backlog
      check(refresh_req == 1'b1, "R9", int'(refresh_req), 1);
      ack_pulse();
      check(pending_count == 0 && refresh_req == 0, "R5", int'(pending_count), 0);

      // R1 cool interval
      wait_inc(t_a);
      check(t_a - t_prev == NORM_I, "R1", t_a - t_prev, NORM_I);
      t_prev = t_a;
      ack_pulse();

      // Vector walk: R4 on the running interval, R1/R2 on the next
      for (int v = 0; v < NVEC; v++) begin
         high_temp = VEC[v][0][0];
         wait_inc(t_a);
         check(t_a - t_prev == VEC[v][1], "R4", t_a - t_prev, VEC[v][1]);
         ack_pulse();
         wait_inc(t_b);
         check(t_b - t_a == VEC[v][2], VEC[v][0] ? "R2" : "R1", t_b - t_a, VEC[v][2]);
         t_prev = t_b;
         ack_pulse();
      end

      // R6 ack with empty backlog is ignored
      ack_pulse();
      check(pending_count == 0, "R6", int'(pending_count), 0);
      check(refresh_req == 0, "R6", int'(refresh_req), 0);

      // R10: go cool, then raise high_temp two edges before an expiry
      high_temp = 1'b0;
      wait_inc(t_a);
      ack_pulse();
      wait_inc(t_prev);
      ack_pulse();
      repeat (NORM_I - 3) @(negedge clk);
      high_temp = 1'b1;
      wait_inc(t_a);
      check(t_a - t_prev == NORM_I, "R10", t_a - t_prev, NORM_I);
      ack_pulse();
      wait_inc(t_b);
      check(t_b - t_a == NORM_I, "R10", t_b - t_a, NORM_I);
      ack_pulse();
      wait_inc(t_x);
      check(t_x - t_b == HOT_I, "R2", t_x - t_b, HOT_I);
      ack_pulse();

      // R5 ack in the expiry cycle leaves the count unchanged
      wait_inc(t_a);
      repeat (HOT_I - 1) @(negedge clk);
      refresh_ack = 1'b1;
      @(negedge clk);
      refresh_ack = 1'b0;
      check(pending_count == 1, "R5", int'(pending_count), 1);

      // R7 fill the backlog without acks
      while (pending_count != PW'(MAXB)) wait_inc(t_a);
      check(refresh_req == 1 && backlog_overflow == 0, "R7", int'(backlog_overflow), 0);
      repeat (HOT_I + 1) @(negedge clk);
      check(pending_count == PW'(MAXB), "R7", int'(pending_count), MAXB);
      check(backlog_overflow == 1, "R8", int'(backlog_overflow), 1);
      ack_pulse();
      check(pending_count == PW'(MAXB - 1), "R5", int'(pending_count), MAXB - 1);
      check(backlog_overflow == 1, "R8", int'(backlog_overflow), 1);

      // R8 only reset clears the flag
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check(backlog_overflow == 0 && pending_count == 0, "R8", int'(backlog_overflow), 0);
      rst_n = 1'b1;

      finished = 1'b1;
      finish_run();
   end

endmodule